// File: doc/BRIEF.md
# Block Cipher Register Front End

This block is the memory-mapped face of a 64-bit block cipher engine. Software, or a DMA engine, talks to it through 32-bit register reads and writes. It holds six key words, a 64-bit chaining value, a mode register, a two-word data window, a byte count, a DMA control register, a revision register and a pair of interrupt status and enable registers. The cipher rounds live in a separate core. The front end drives that core through a narrow port: a one-cycle start, the encrypt and triple-key mode bits, the key and the input block. It then waits for the core's done pulse and output block.

Each block moves through a three-state sequence. In LOAD the window accepts input. Writing word 0 and then word 1 moves the block to BUSY and starts the core. When the core reports done, the block moves to DRAIN and the result can be read from the window. Reading word 1 returns the block to LOAD. The three transitions are LOAD to BUSY on an accepted word-1 write, BUSY to DRAIN on core done, and DRAIN to LOAD on a word-1 read. In chaining mode the front end applies the chaining XOR itself and keeps the chaining value current after every block, so the final value can be read back. Data movement can be paced by the two interrupt flags or by the two DMA request lines. A DMA run covers a programmed byte count and stops by itself.

Top module: `blkciph_frontend`

## Requirements
- R1: After reset the mode register reads 0x2 (input ready, all mode bits clear). The interrupt status reads 0x2 and the interrupt enable reads 0. The irq output and both DMA request lines are low.
- R2: Key word i (i = 0..5) is written and read at byte offset 0x14 - ((i XOR 1) * 4) and appears on core_key bits [32i+31:32i]. Single-key mode uses only words 0 and 1.
- R3: A block is written as data word 0 at 0x28 (block bits 31:0), then data word 1 at 0x2C (bits 63:32). The accepted word-1 write produces exactly one core_start pulse one cycle long. After done, the result is read back from the same two offsets. With chaining off (ECB), core_blk_in is the written block and the result is core_blk_out.
- R4: With chaining on and encrypt set, core_blk_in is the block XOR the chaining value (IV words at 0x18 for bits 31:0 and 0x1C for bits 63:32). Both the result and the new chaining value equal core_blk_out.
- R5: With chaining on and encrypt clear, the result is core_blk_out XOR the chaining value, and the new chaining value is the written input block.
- R6: Mode register bit 1 reads 1 only in LOAD and bit 0 reads 1 only in DRAIN. An accepted word-1 write enters BUSY, core done enters DRAIN, and a read of data word 1 in DRAIN returns to LOAD.
- R7: A data write outside LOAD is dropped. It starts no core operation and leaves the pending result unchanged.
- R8: Writes to the key, IV or mode registers during BUSY are ignored.
- R9: Interrupt status bit 1 (input wanted) is set on entering LOAD and after reset. Bit 2 (output available) is set on entering DRAIN. A set bit stays set until the status register at 0x3C is written with that bit 0; writing 1 keeps it. The enable register at 0x40 uses the same positions, and irq is the OR over bits of status AND enable.
- R10: The revision register at 0x30 reads the major version in bits 10:8 and the minor version in bits 5:0.
- R11: The DMA register at 0x34 has go (bit 0), input request enable (bit 5) and output request enable (bit 6). Writing go as 1 loads the remaining count from the length register at 0x24. dma_in_req is high in LOAD while go and bit 5 are set and the count is nonzero. dma_out_req is high in DRAIN while go and bit 6 are set. Each word-1 read in DRAIN lowers the count by 8, and go clears when the count reaches 0.
- R12: Mode register bit 4 enables chaining, bit 3 selects triple-key mode and bit 2 selects encrypt. Bits 3 and 2 drive core_triple and core_encrypt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on data word 1) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt line |
| dma_in_req | output | 1 | Input DMA request |
| dma_out_req | output | 1 | Output DMA request |
| core_start | output | 1 | One-cycle start to the cipher core |
| core_encrypt | output | 1 | Core direction, 1 = encrypt |
| core_triple | output | 1 | Core triple-key mode |
| core_key | output | 192 | Key words 5..0 |
| core_blk_in | output | 64 | Block to the core |
| core_done | input | 1 | Core result valid |
| core_blk_out | input | 64 | Core result |

## Verification
Four kinds of rule are checked on every cycle: the one-cycle shape of the start pulse, the absence of starts outside LOAD, the state transitions on push and on done, and a frozen chaining value throughout BUSY. The same per-cycle checks cover the output flag being set on entering DRAIN, the mutual exclusion of the two DMA requests, and the silence of the input request once the count is spent. The arithmetic content can only be shown by bench scenarios run against an independent reversible core model. This covers the chaining XOR in both directions, the IV readback after a chain, and the swapped key placement. Those scenarios also show that dropped and ignored writes leave state unchanged, that the sticky status bits follow the write-back rule, and that a DMA run stops after its byte count.

// File: rtl/blkciph_fe_pkg.sv
package blkciph_fe_pkg;
    typedef enum logic [1:0] {
        S_LOAD  = 2'd0,
        S_BUSY  = 2'd1,
        S_DRAIN = 2'd2
    } fe_state_e;

    localparam int BLK_W      = 64;
    localparam int BLK_BYTES  = BLK_W / 8;
    localparam int KEY_WORDS  = 6;

    localparam int OFS_IV0    = 'h18;
    localparam int OFS_IV1    = 'h1C;
    localparam int OFS_CTRL   = 'h20;
    localparam int OFS_LEN    = 'h24;
    localparam int OFS_DAT0   = 'h28;
    localparam int OFS_DAT1   = 'h2C;
    localparam int OFS_REV    = 'h30;
    localparam int OFS_DMA    = 'h34;
    localparam int OFS_IST    = 'h3C;
    localparam int OFS_IEN    = 'h40;

    function automatic int key_ofs(input int idx);
        return 'h14 - ((idx ^ 1) * 4);
    endfunction
endpackage

// File: rtl/blkciph_fe_fsm.sv
module blkciph_fe_fsm
    import blkciph_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      blk_push,
    input  logic      core_done,
    input  logic      blk_pop,
    output fe_state_e state,
    output logic      core_start,
    output logic      enter_load,
    output logic      enter_drain
);
    fe_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            S_LOAD:  if (blk_push)  nxt = S_BUSY;
            S_BUSY:  if (core_done) nxt = S_DRAIN;
            S_DRAIN: if (blk_pop)   nxt = S_LOAD;
            default: nxt = S_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_LOAD;
        else        state <= nxt;
    end

    // output process: start pulse plus transition events
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_start <= 1'b0;
        else        core_start <= (state == S_LOAD) && blk_push;
    end

    assign enter_load  = (state == S_DRAIN) && blk_pop;
    assign enter_drain = (state == S_BUSY) && core_done;
endmodule

// File: rtl/blkciph_fe_chain.sv
module blkciph_fe_chain #(
    parameter int W = 64
) (
    input  logic         chain_en,
    input  logic         encrypt,
    input  logic [W-1:0] iv,
    input  logic [W-1:0] raw_in,
    input  logic [W-1:0] core_out,
    output logic [W-1:0] core_in,
    output logic [W-1:0] result,
    output logic [W-1:0] iv_next
);
    assign core_in = (chain_en && encrypt)  ? (raw_in ^ iv)   : raw_in;
    assign result  = (chain_en && !encrypt) ? (core_out ^ iv) : core_out;
    assign iv_next = encrypt ? core_out : raw_in;
endmodule

// File: rtl/blkciph_frontend.sv
module blkciph_frontend
    import blkciph_fe_pkg::*;
#(
    parameter int AW        = 8,
    parameter int LEN_W     = 16,
    parameter int REV_MAJOR = 2,
    parameter int REV_MINOR = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [AW-1:0]           bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    irq,
    output logic                    dma_in_req,
    output logic                    dma_out_req,
    output logic                    core_start,
    output logic                    core_encrypt,
    output logic                    core_triple,
    output logic [KEY_WORDS*32-1:0] core_key,
    output logic [BLK_W-1:0]        core_blk_in,
    input  logic                    core_done,
    input  logic [BLK_W-1:0]        core_blk_out
);
    fe_state_e        state;
    logic             enter_load, enter_drain;
    logic [31:0]      key_q [KEY_WORDS];
    logic [BLK_W-1:0] iv_q, din_q, dout_q;
    logic [BLK_W-1:0] result, iv_next;
    logic             cbc_q, tri_q, enc_q;
    logic [LEN_W-1:0] len_q, rem_q;
    logic             go_q, dma_ien_q, dma_oen_q;
    logic             ist_in_q, ist_out_q, ien_in_q, ien_out_q;
    logic             busy, blk_push, blk_pop;

    function automatic logic hit(input logic [AW-1:0] a, input int ofs);
        return a == AW'(ofs);
    endfunction

    assign busy     = (state == S_BUSY);
    assign blk_push = bus_wr && hit(bus_addr, OFS_DAT1) && (state == S_LOAD);
    assign blk_pop  = bus_rd && hit(bus_addr, OFS_DAT1) && (state == S_DRAIN);

    blkciph_fe_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .blk_push(blk_push), .core_done(core_done),
        .blk_pop(blk_pop), .state(state), .core_start(core_start),
        .enter_load(enter_load), .enter_drain(enter_drain)
    );

    blkciph_fe_chain #(.W(BLK_W)) u_chain (
        .chain_en(cbc_q), .encrypt(enc_q), .iv(iv_q), .raw_in(din_q),
        .core_out(core_blk_out), .core_in(core_blk_in), .result(result),
        .iv_next(iv_next)
    );

    // key words at swapped-pair, descending offsets
    for (genvar gi = 0; gi < KEY_WORDS; gi++) begin : g_key
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) key_q[gi] <= '0;
            else if (bus_wr && !busy && hit(bus_addr, key_ofs(gi))) key_q[gi] <= bus_wdata;
        end
        assign core_key[32*gi +: 32] = key_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            iv_q <= '0; din_q <= '0; dout_q <= '0;
            cbc_q <= 1'b0; tri_q <= 1'b0; enc_q <= 1'b0;
        end else begin
            if (bus_wr && !busy) begin
                if (hit(bus_addr, OFS_IV0)) iv_q[31:0]  <= bus_wdata;
                if (hit(bus_addr, OFS_IV1)) iv_q[63:32] <= bus_wdata;
                if (hit(bus_addr, OFS_CTRL)) begin
                    cbc_q <= bus_wdata[4];
                    tri_q <= bus_wdata[3];
                    enc_q <= bus_wdata[2];
                end
            end
            if (bus_wr && (state == S_LOAD) && hit(bus_addr, OFS_DAT0)) din_q[31:0] <= bus_wdata;
            if (blk_push) din_q[63:32] <= bus_wdata;
            if (enter_drain) begin
                dout_q <= result;
                if (cbc_q) iv_q <= iv_next;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ist_in_q <= 1'b1; ist_out_q <= 1'b0;
            ien_in_q <= 1'b0; ien_out_q <= 1'b0;
        end else begin
            if (bus_wr && hit(bus_addr, OFS_IEN)) begin
                ien_in_q  <= bus_wdata[1];
                ien_out_q <= bus_wdata[2];
            end
            ist_in_q  <= enter_load  | (ist_in_q  & ~(bus_wr && hit(bus_addr, OFS_IST) && !bus_wdata[1]));
            ist_out_q <= enter_drain | (ist_out_q & ~(bus_wr && hit(bus_addr, OFS_IST) && !bus_wdata[2]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0; rem_q <= '0;
            go_q <= 1'b0; dma_ien_q <= 1'b0; dma_oen_q <= 1'b0;
        end else begin
            if (bus_wr && hit(bus_addr, OFS_LEN)) len_q <= bus_wdata[LEN_W-1:0];
            if (blk_pop && go_q) begin
                if (rem_q <= LEN_W'(BLK_BYTES)) begin
                    rem_q <= '0;
                    go_q  <= 1'b0;
                end else begin
                    rem_q <= rem_q - LEN_W'(BLK_BYTES);
                end
            end
            if (bus_wr && hit(bus_addr, OFS_DMA)) begin
                go_q      <= bus_wdata[0];
                dma_ien_q <= bus_wdata[5];
                dma_oen_q <= bus_wdata[6];
                if (bus_wdata[0] && !go_q) rem_q <= len_q;
            end
        end
    end

    assign dma_in_req   = go_q && dma_ien_q && (state == S_LOAD) && (rem_q != '0);
    assign dma_out_req  = go_q && dma_oen_q && (state == S_DRAIN);
    assign irq          = (ist_in_q & ien_in_q) | (ist_out_q & ien_out_q);
    assign core_encrypt = enc_q;
    assign core_triple  = tri_q;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < KEY_WORDS; i++)
            if (hit(bus_addr, key_ofs(i))) bus_rdata = key_q[i];
        if (hit(bus_addr, OFS_IV0))  bus_rdata = iv_q[31:0];
        if (hit(bus_addr, OFS_IV1))  bus_rdata = iv_q[63:32];
        if (hit(bus_addr, OFS_CTRL)) bus_rdata = {27'd0, cbc_q, tri_q, enc_q,
                                                  state == S_LOAD, state == S_DRAIN};
        if (hit(bus_addr, OFS_LEN))  bus_rdata = 32'(len_q);
        if (hit(bus_addr, OFS_DAT0) && state == S_DRAIN) bus_rdata = dout_q[31:0];
        if (hit(bus_addr, OFS_DAT1) && state == S_DRAIN) bus_rdata = dout_q[63:32];
        if (hit(bus_addr, OFS_REV))  bus_rdata = {21'd0, 3'(REV_MAJOR), 2'd0, 6'(REV_MINOR)};
        if (hit(bus_addr, OFS_DMA))  bus_rdata = {25'd0, dma_oen_q, dma_ien_q, 4'd0, go_q};
        if (hit(bus_addr, OFS_IST))  bus_rdata = {29'd0, ist_out_q, ist_in_q, 1'b0};
        if (hit(bus_addr, OFS_IEN))  bus_rdata = {29'd0, ien_out_q, ien_in_q, 1'b0};
    end
endmodule

// File: rtl/blkciph_frontend_chk.sv
module blkciph_frontend_chk
    import blkciph_fe_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input fe_state_e        state,
    input logic             blk_push,
    input logic             core_start,
    input logic             core_done,
    input logic [BLK_W-1:0] iv_q,
    input logic [LEN_W-1:0] rem_q,
    input logic             ist_out_q,
    input logic             dma_in_req,
    input logic             dma_out_req
);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);
    // R7
    no_start_outside_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_LOAD) |=> !core_start);
    // R6
    push_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && blk_push) |=> (state == S_BUSY));
    // R6
    done_to_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && core_done) |=> (state == S_DRAIN));
    // R8
    iv_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && $past(state) == S_BUSY) |-> $stable(iv_q));
    // R9
    out_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && core_done) |=> ist_out_q);
    // R11
    dma_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_in_req && dma_out_req));
    // R11
    dma_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rem_q == '0) |-> !dma_in_req);
endmodule

bind blkciph_frontend blkciph_frontend_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .blk_push(blk_push),
    .core_start(core_start), .core_done(core_done), .iv_q(iv_q), .rem_q(rem_q),
    .ist_out_q(ist_out_q), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req)
);

// File: tb/sim_blkciph_frontend.sv
module sim_blkciph_frontend;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq, dma_in_req, dma_out_req;
    logic          core_start, core_encrypt, core_triple;
    logic [191:0]  core_key;
    logic [63:0]   core_blk_in;
    logic          core_done = 1'b0;
    logic [63:0]   core_blk_out = '0;

    int n_tests = 0, n_fail = 0, n_starts = 0, core_lat = 2;
    logic [63:0] last_core_in = '0;
    logic [31:0] kb [6];
    logic [63:0] ivm = '0;
    logic cbc_m = 0, enc_m = 0, tri_m = 0;

    always #2 clk = ~clk;

    blkciph_frontend u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .core_start(core_start), .core_encrypt(core_encrypt),
        .core_triple(core_triple), .core_key(core_key),
        .core_blk_in(core_blk_in), .core_done(core_done),
        .core_blk_out(core_blk_out)
    );

    function automatic logic [63:0] rotl8(input logic [63:0] x);
        return {x[55:0], x[63:56]};
    endfunction
    function automatic logic [63:0] rotr8(input logic [63:0] x);
        return {x[7:0], x[63:8]};
    endfunction
    function automatic logic [63:0] toy_core(input logic [63:0] d, input logic e,
                                             input logic [63:0] kf);
        return e ? rotl8(d ^ kf) : (rotr8(d) ^ kf);
    endfunction
    function automatic logic [7:0] kaddr(input int i);
        return 8'(32'h14 - ((i ^ 1) * 4));
    endfunction
    function automatic logic [63:0] model_kf();
        logic [63:0] k;
        k = {kb[1], kb[0]};
        if (tri_m) k = k ^ {kb[3], kb[2]} ^ {kb[5], kb[4]};
        return k;
    endfunction

    // stand-in cipher core
    initial begin
        forever begin
            @(negedge clk);
            if (core_start === 1'b1) begin
                logic [63:0] cin, kf;
                logic        e;
                cin = core_blk_in;
                e = core_encrypt;
                kf = core_key[63:0];
                if (core_triple) kf = kf ^ core_key[127:64] ^ core_key[191:128];
                last_core_in = cin;
                n_starts++;
                repeat (core_lat) @(negedge clk);
                core_blk_out = toy_core(cin, e, kf);
                core_done = 1'b1;
                @(negedge clk);
                core_done = 1'b0;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_key(input int i, input logic [31:0] v);
        bwrite(kaddr(i), v);
        kb[i] = v;
    endtask
    task automatic set_iv(input logic [63:0] v);
        bwrite(8'h18, v[31:0]);
        bwrite(8'h1C, v[63:32]);
        ivm = v;
    endtask
    task automatic set_mode(input logic c, input logic e, input logic t);
        bwrite(8'h20, {27'd0, c, t, e, 2'b00});
        cbc_m = c; enc_m = e; tri_m = t;
    endtask

    task automatic wait_out();
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            bread(8'h20, v);
            if (v[0]) break;
        end
    endtask

    task automatic expect_blk(input logic [63:0] blk, output logic [63:0] exp_out,
                              output logic [63:0] exp_cin);
        logic [63:0] co;
        if (cbc_m && enc_m) begin
            exp_cin = blk ^ ivm;
            co = toy_core(exp_cin, 1'b1, model_kf());
            exp_out = co; ivm = co;
        end else if (cbc_m) begin
            exp_cin = blk;
            co = toy_core(blk, 1'b0, model_kf());
            exp_out = co ^ ivm; ivm = blk;
        end else begin
            exp_cin = blk;
            exp_out = toy_core(blk, enc_m, model_kf());
        end
    endtask

    task automatic run_block(input string tag, input logic [63:0] blk,
                             output logic [63:0] got);
        logic [63:0] eo, ec;
        logic [31:0] r0, r1;
        expect_blk(blk, eo, ec);
        bwrite(8'h28, blk[31:0]);
        bwrite(8'h2C, blk[63:32]);
        wait_out();
        bread(8'h28, r0);
        bread(8'h2C, r1);
        got = {r1, r0};
        chk({tag, " result"}, got, eo);
        chk({tag, " core input"}, last_core_in, ec);
    endtask

    initial begin
        #(4 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] got, ct0, ct1, ivs, p0, p1;
        int st0;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 6; i++) kb[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 revision
        bread(8'h20, v); chk("R1 ctrl reset", 64'(v), 64'h2);
        bread(8'h3C, v); chk("R1 irq status reset", 64'(v), 64'h2);
        bread(8'h40, v); chk("R1 irq enable reset", 64'(v), 64'h0);
        chk("R1 outputs reset", {61'd0, irq, dma_in_req, dma_out_req}, 64'h0);
        bread(8'h30, v); chk("R10 revision", 64'(v), 64'h205);

        // R2 key placement
        for (int i = 0; i < 6; i++) set_key(i, 32'hA0000000 + 32'(i) * 32'h01010101);
        for (int i = 0; i < 6; i++) begin
            chk("R2 key port", 64'(core_key[32*i +: 32]), 64'(kb[i]));
            bread(kaddr(i), v);
            chk("R2 key readback", 64'(v), 64'(kb[i]));
        end

        // R12 mode pins, R3 ECB, R6 states
        set_mode(1'b0, 1'b1, 1'b1);
        chk("R12 mode pins", {62'd0, core_triple, core_encrypt}, 64'h3);
        set_mode(1'b0, 1'b1, 1'b0);
        chk("R12 mode pins single", {62'd0, core_triple, core_encrypt}, 64'h1);
        st0 = n_starts;
        bwrite(8'h28, 32'h11223344);
        bread(8'h20, v); chk("R6 still loading after word0", 64'(v[1:0]), 64'h2);
        bwrite(8'h2C, 32'h55667788);
        bread(8'h20, v); chk("R6 input ready drops", 64'(v[1]), 64'h0);
        wait_out();
        chk("R3 one start per block", 64'(n_starts - st0), 64'h1);
        chk("R3 ECB core input", last_core_in, 64'h5566778811223344);
        bread(8'h28, v); p0[31:0] = v;
        bread(8'h20, v); chk("R6 output ready held", 64'(v[1:0]), 64'h1);
        bread(8'h2C, v); p0[63:32] = v;
        chk("R3 ECB result", p0, toy_core(64'h5566778811223344, 1'b1, model_kf()));
        bread(8'h20, v); chk("R6 back to load", 64'(v[1:0]), 64'h2);

        // R4 CBC encrypt chain
        set_mode(1'b1, 1'b1, 1'b0);
        set_iv(64'h0F0E0D0C0B0A0908);
        ivs = ivm;
        run_block("R4 cbc enc 0", 64'h0123456789ABCDEF, ct0);
        run_block("R4 cbc enc 1", 64'hFEDCBA9876543210, ct1);
        bread(8'h18, v); got[31:0] = v;
        bread(8'h1C, v); got[63:32] = v;
        chk("R4 final IV", got, ct1);

        // R5 CBC decrypt recovers plaintext
        set_mode(1'b1, 1'b0, 1'b0);
        set_iv(ivs);
        run_block("R5 cbc dec 0", ct0, p0);
        run_block("R5 cbc dec 1", ct1, p1);
        chk("R5 plaintext 0", p0, 64'h0123456789ABCDEF);
        chk("R5 plaintext 1", p1, 64'hFEDCBA9876543210);
        bread(8'h18, v); got[31:0] = v;
        bread(8'h1C, v); got[63:32] = v;
        chk("R5 final IV", got, ct1);

        // R7 data writes outside LOAD dropped
        set_mode(1'b0, 1'b0, 1'b1);
        expect_blk(64'h1357924680ACE000, ct0, ivs);
        bwrite(8'h28, 32'h80ACE000);
        bwrite(8'h2C, 32'h13579246);
        wait_out();
        st0 = n_starts;
        bwrite(8'h28, 32'hDEADBEEF);
        bwrite(8'h2C, 32'hCAFEF00D);
        repeat (6) @(negedge clk);
        chk("R7 no extra start", 64'(n_starts - st0), 64'h0);
        bread(8'h20, v); chk("R7 still draining", 64'(v[1:0]), 64'h1);
        bread(8'h28, v); got[31:0] = v;
        bread(8'h2C, v); got[63:32] = v;
        chk("R7 result untouched", got, ct0);

        // R8 writes during BUSY ignored
        core_lat = 10;
        set_mode(1'b0, 1'b1, 1'b0);
        set_iv(64'h0000111122223333);
        set_key(0, 32'h0BADC0DE);
        bwrite(8'h28, 32'h1);
        bwrite(8'h2C, 32'h2);
        bwrite(8'h18, 32'hFFFFFFFF);
        bwrite(8'h20, 32'h1C);
        bwrite(kaddr(0), 32'h99999999);
        wait_out();
        bread(8'h18, v); chk("R8 IV unchanged", 64'(v), 64'h22223333);
        bread(8'h20, v); chk("R8 mode unchanged", 64'(v[4:2]), 64'h1);
        bread(kaddr(0), v); chk("R8 key unchanged", 64'(v), 64'h0BADC0DE);
        bread(8'h28, v); bread(8'h2C, v);
        core_lat = 2;

        // R9 interrupt flags
        bwrite(8'h3C, 32'h0);
        bwrite(8'h40, 32'h6);
        bread(8'h3C, v); chk("R9 status cleared", 64'(v), 64'h0);
        chk("R9 irq low", 64'(irq), 64'h0);
        bwrite(8'h28, 32'h3);
        bwrite(8'h2C, 32'h4);
        wait_out();
        bread(8'h3C, v); chk("R9 output flag", 64'(v), 64'h4);
        chk("R9 irq on output", 64'(irq), 64'h1);
        bwrite(8'h3C, 32'h4);
        bread(8'h3C, v); chk("R9 write one keeps", 64'(v), 64'h4);
        bwrite(8'h3C, 32'h0);
        chk("R9 irq cleared", 64'(irq), 64'h0);
        bread(8'h28, v); bread(8'h2C, v);
        bread(8'h3C, v); chk("R9 input flag on load", 64'(v), 64'h2);
        chk("R9 irq on input", 64'(irq), 64'h1);
        bwrite(8'h40, 32'h4);
        chk("R9 masked", 64'(irq), 64'h0);
        bwrite(8'h40, 32'h0);

        // random mix, R3 R4 R5 R12
        for (int n = 0; n < 24; n++) begin
            logic [31:0] rv;
            rv = $urandom;
            if (rv[0]) for (int i = 0; i < 6; i++) set_key(i, $urandom);
            set_mode(rv[1], rv[2], rv[3]);
            set_iv({$urandom, $urandom});
            for (int b = 0; b <= int'(rv[5:4]); b++) begin
                run_block(rv[1] ? (rv[2] ? "R4 random" : "R5 random") : "R3 random",
                          {$urandom, $urandom}, got);
            end
            if (rv[1]) begin
                bread(8'h18, v); got[31:0] = v;
                bread(8'h1C, v); got[63:32] = v;
                chk("R4 R5 random IV", got, ivm);
            end
        end

        // R11 DMA paced run of three blocks
        set_mode(1'b0, 1'b1, 1'b0);
        bwrite(8'h24, 32'd24);
        bwrite(8'h34, 32'h61);
        chk("R11 requests after go", {62'd0, dma_in_req, dma_out_req}, 64'h2);
        for (int b = 0; b < 3; b++) begin
            logic [63:0] blk, eo, ec;
            logic [31:0] r0, r1;
            blk = {$urandom, $urandom};
            for (int w = 0; w < 50 && !dma_in_req; w++) @(negedge clk);
            chk("R11 input request", 64'(dma_in_req), 64'h1);
            expect_blk(blk, eo, ec);
            bwrite(8'h28, blk[31:0]);
            bwrite(8'h2C, blk[63:32]);
            for (int w = 0; w < 50 && !dma_out_req; w++) @(negedge clk);
            chk("R11 output request", {62'd0, dma_in_req, dma_out_req}, 64'h1);
            bread(8'h28, r0);
            bread(8'h2C, r1);
            chk("R11 dma result", {r1, r0}, eo);
        end
        chk("R11 requests idle at end", {62'd0, dma_in_req, dma_out_req}, 64'h0);
        bread(8'h34, v); chk("R11 go cleared", 64'(v), 64'h60);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule